// File: doc/BRIEF.md
# Self-Initializing Bus Master Role Controller

This block sequences the role of a two-wire bus device that wakes up as a plain slave receiver and later turns itself into a bus master. After reset it answers write addressing at its own 7-bit or 10-bit address. The first data byte a remote master writes to it is kept as the destination address for the device's later traffic. When that write is closed by a stop condition, the block leaves the slave role for good. From then on it competes for the bus and sends its data framed as a general call: the byte 0x00, then an identity byte, then the payload.

The block works at byte level only. A separate bit engine detects start, stop and received bytes and forwards them on the slave port. It also carries out start, byte and stop commands for the master side, and reports the receiver's acknowledge and any lost arbitration.

Slave-side states: `SL_IDLE` (not addressed, every byte refused), `SL_ADDR` (start seen, the next byte is the address), `SL_ADR10` (10-bit high part matched, low byte expected), `SL_DATA` (addressed, the next byte is the destination), `SL_DONE` (destination stored, waiting for stop). Transitions: a stop goes to `SL_IDLE` and, from `SL_DONE`, hands over to the master role. A start goes to `SL_ADDR`, or stays in `SL_DONE`. A matching address byte goes to `SL_ADR10` or `SL_DATA`, and any other address byte goes to `SL_IDLE`. A data byte goes from `SL_DATA` to `SL_DONE`.

Master-side states: `MS_OFF` (slave role active), `MS_WAIT` (wait for data and a free bus), `MS_START`, `MS_GC` (general-call byte), `MS_ID` (identity byte), `MS_FETCH` (wait for the next payload byte), `MS_DATA`, `MS_STOP`. Transitions: lost arbitration in `MS_START`, `MS_GC`, `MS_ID` or `MS_DATA` goes back to `MS_WAIT`. A refused general-call byte, a refused identity byte, a refused data byte or a last data byte goes to `MS_STOP`. A completed stop goes to `MS_WAIT`.

Top module: `selfinit_hw_master`

## Requirements
- R1: While reset is high and one clock after it, `sl_ack`, `m_cmd_vld`, `src_pop`, `master_mode`, `err` are 0 and `dump_addr` is 0x00.
- R2: In 7-bit mode, after a start, the first byte is acknowledged only if it equals {OWN_ADDR[6:0], 0}; any other value is refused.
- R3: In 10-bit mode, after a start, the first byte is acknowledged only if it equals {5'b11110, OWN_ADDR[9:8], 0}. The following byte is acknowledged only if it equals OWN_ADDR[7:0].
- R4: A first byte with bit 0 set (a read) is never acknowledged in either addressing mode.
- R5: The first byte after a successful write addressing is acknowledged and stored on `dump_addr`; further bytes before the stop are refused. The stop makes `master_mode` 1 on the next clock, and it stays 1 until reset.
- R6: A stop that arrives before the destination byte leaves the block in the slave role.
- R7: In the master role, when `src_vld` and `m_bus_free` are both 1, the block issues commands in this order: start (`m_cmd` 2'b01), a byte (`m_cmd` 2'b10) of 0x00, then a byte of {OWN_ADDR[6:0], 1}.
- R8: After an acknowledged header, the block sends the source bytes in order and pulses `src_pop` as each one completes. After the byte flagged `src_last` it issues stop (`m_cmd` 2'b11).
- R9: A refused data byte is followed at once by stop; later source bytes are not popped.
- R10: Lost arbitration drops `m_cmd_vld` at once and pops nothing. The block then waits for a free bus and repeats the whole transfer from the start command.
- R11: A refused general-call byte leads to stop without any data byte, and sets `err`, which stays 1 until reset.
- R12: In the master role `sl_ack` is never asserted, whether for the former address, the general-call byte or any other byte.
- R13: A command stays valid, with the same `m_cmd`, until `m_rsp_vld` or `m_arb_lost` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sl_start | input | 1 | Start or repeated start seen by the bit engine |
| sl_stop | input | 1 | Stop seen by the bit engine |
| sl_vld | input | 1 | Received byte present |
| sl_byte | input | 8 | Received byte |
| sl_ack | output | 1 | Acknowledge for the byte on `sl_byte` (same cycle) |
| m_bus_free | input | 1 | Bus is idle |
| m_cmd_vld | output | 1 | Command to the bit engine is valid |
| m_cmd | output | 2 | 01 start, 10 byte, 11 stop |
| m_txd | output | 8 | Byte to transmit with a byte command |
| m_rsp_vld | input | 1 | Current command completed |
| m_rsp_ack | input | 1 | Receiver acknowledged the byte |
| m_arb_lost | input | 1 | Arbitration lost during the current command |
| src_vld | input | 1 | Payload byte available |
| src_data | input | 8 | Payload byte, held until popped |
| src_last | input | 1 | Payload byte is the last of a transfer |
| src_pop | output | 1 | Payload byte consumed |
| master_mode | output | 1 | Block has left the slave role |
| dump_addr | output | 8 | Stored destination address |
| err | output | 1 | General-call byte was refused |

## Verification
A slave-side state stuck at the wrong place shows at `sl_ack` in the very cycle of the next received byte. The acknowledge is combinational, so an address decoded against the wrong bits, or a read that is answered, is visible on the first byte after a start. A wrong master-side state shows on `m_cmd_vld`, `m_cmd` and `m_txd` at the next cycle after the response that should have moved it. A wrong pop shows on `src_pop` during that same response cycle. The sweeps feed every possible first byte to both addressing modes, and the master scenarios answer each command with acknowledge, refusal or lost arbitration, so each transition is observed one cycle after it is taken.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int CMD_W  = 2;

    localparam logic [CMD_W-1:0] CMD_START = 2'b01;
    localparam logic [CMD_W-1:0] CMD_BYTE  = 2'b10;
    localparam logic [CMD_W-1:0] CMD_STOP  = 2'b11;

    localparam logic [4:0]        TEN_BIT_TAG = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_BYTE     = 8'h00;

    typedef enum logic [2:0] {
        SL_IDLE, SL_ADDR, SL_ADR10, SL_DATA, SL_DONE
    } sl_state_e;

    typedef enum logic [2:0] {
        MS_OFF, MS_WAIT, MS_START, MS_GC, MS_ID, MS_FETCH, MS_DATA, MS_STOP
    } ms_state_e;
endpackage

// File: rtl/hwm_slave_rx.sv
module hwm_slave_rx
    import hwm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 10'h02C,
    parameter bit                ADDR10   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sl_start,
    input  logic              sl_stop,
    input  logic              sl_vld,
    input  logic [BYTE_W-1:0] sl_byte,
    output logic              sl_ack,
    output logic [BYTE_W-1:0] dump_addr,
    output logic              prog_done
);
    sl_state_e st, nxt;
    logic first_hit, low_hit, byte_in;

    generate
        if (ADDR10) begin : g_ten
            assign first_hit = (sl_byte[7:3] == TEN_BIT_TAG) &&
                               (sl_byte[2:1] == OWN_ADDR[9:8]) && !sl_byte[0];
        end else begin : g_seven
            assign first_hit = (sl_byte[7:1] == OWN_ADDR[6:0]) && !sl_byte[0];
        end
    endgenerate

    assign low_hit = (sl_byte == OWN_ADDR[7:0]);
    assign byte_in = enable && sl_vld && !sl_start && !sl_stop;

    always_ff @(posedge clk) begin
        if (rst) st <= SL_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!enable) begin
            nxt = SL_IDLE;
        end else if (sl_stop) begin
            nxt = SL_IDLE;
        end else if (sl_start) begin
            nxt = (st == SL_DONE) ? SL_DONE : SL_ADDR;
        end else if (sl_vld) begin
            unique case (st)
                SL_ADDR:  nxt = first_hit ? (ADDR10 ? SL_ADR10 : SL_DATA) : SL_IDLE;
                SL_ADR10: nxt = low_hit ? SL_DATA : SL_IDLE;
                SL_DATA:  nxt = SL_DONE;
                default:  nxt = st;
            endcase
        end
    end

    always_comb begin
        sl_ack    = 1'b0;
        prog_done = enable && sl_stop && (st == SL_DONE);
        if (byte_in) begin
            unique case (st)
                SL_ADDR:  sl_ack = first_hit;
                SL_ADR10: sl_ack = low_hit;
                SL_DATA:  sl_ack = 1'b1;
                default:  sl_ack = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          dump_addr <= '0;
        else if (byte_in && st == SL_DATA) dump_addr <= sl_byte;
    end

    p_read_nack_r4: assert property (@(posedge clk) disable iff (rst)
        (sl_vld && sl_byte[0] && st == SL_ADDR) |-> !sl_ack);

    p_dump_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st == SL_DONE) |=> $stable(dump_addr));
endmodule

// File: rtl/hwm_master_tx.sv
module hwm_master_tx
    import hwm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 10'h02C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bus_free,
    output logic              cmd_vld,
    output logic [CMD_W-1:0]  cmd,
    output logic [BYTE_W-1:0] txd,
    input  logic              rsp_vld,
    input  logic              rsp_ack,
    input  logic              arb_lost,
    input  logic              src_vld,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_pop,
    output logic              err
);
    localparam logic [BYTE_W-1:0] ID_BYTE = {OWN_ADDR[6:0], 1'b1};

    ms_state_e st, nxt;
    logic done_ok;

    assign done_ok = rsp_vld && !arb_lost;

    always_ff @(posedge clk) begin
        if (rst) st <= MS_OFF;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            MS_OFF:   if (enable) nxt = MS_WAIT;
            MS_WAIT:  if (src_vld && bus_free) nxt = MS_START;
            MS_START: if (arb_lost) nxt = MS_WAIT;
                      else if (rsp_vld) nxt = MS_GC;
            MS_GC:    if (arb_lost) nxt = MS_WAIT;
                      else if (rsp_vld) nxt = rsp_ack ? MS_ID : MS_STOP;
            MS_ID:    if (arb_lost) nxt = MS_WAIT;
                      else if (rsp_vld) nxt = rsp_ack ? MS_FETCH : MS_STOP;
            MS_FETCH: if (src_vld) nxt = MS_DATA;
            MS_DATA:  if (arb_lost) nxt = MS_WAIT;
                      else if (rsp_vld) nxt = (!rsp_ack || src_last) ? MS_STOP : MS_FETCH;
            MS_STOP:  if (rsp_vld) nxt = MS_WAIT;
            default:  nxt = MS_OFF;
        endcase
    end

    always_comb begin
        cmd_vld = 1'b0;
        cmd     = CMD_START;
        txd     = '0;
        src_pop = 1'b0;
        unique case (st)
            MS_START: begin cmd_vld = 1'b1; cmd = CMD_START; end
            MS_GC:    begin cmd_vld = 1'b1; cmd = CMD_BYTE; txd = GC_BYTE; end
            MS_ID:    begin cmd_vld = 1'b1; cmd = CMD_BYTE; txd = ID_BYTE; end
            MS_DATA:  begin
                cmd_vld = 1'b1; cmd = CMD_BYTE; txd = src_data;
                src_pop = done_ok;
            end
            MS_STOP:  begin cmd_vld = 1'b1; cmd = CMD_STOP; end
            default:  cmd_vld = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else if (st == MS_GC && done_ok && !rsp_ack) err <= 1'b1;
    end

    p_cmd_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && !rsp_vld && !arb_lost) |=> (cmd_vld && $stable(cmd)));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_pop_valid_r8: assert property (@(posedge clk) disable iff (rst)
        src_pop |-> (src_vld && rsp_vld));

    p_arb_release_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && arb_lost && cmd != CMD_STOP) |=> !cmd_vld);
endmodule

// File: rtl/selfinit_hw_master.sv
module selfinit_hw_master
    import hwm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 10'h02C,
    parameter bit                ADDR10   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sl_start,
    input  logic              sl_stop,
    input  logic              sl_vld,
    input  logic [7:0]        sl_byte,
    output logic              sl_ack,
    input  logic              m_bus_free,
    output logic              m_cmd_vld,
    output logic [1:0]        m_cmd,
    output logic [7:0]        m_txd,
    input  logic              m_rsp_vld,
    input  logic              m_rsp_ack,
    input  logic              m_arb_lost,
    input  logic              src_vld,
    input  logic [7:0]        src_data,
    input  logic              src_last,
    output logic              src_pop,
    output logic              master_mode,
    output logic [7:0]        dump_addr,
    output logic              err
);
    logic prog_done;

    always_ff @(posedge clk) begin
        if (rst)            master_mode <= 1'b0;
        else if (prog_done) master_mode <= 1'b1;
    end

    hwm_slave_rx #(.OWN_ADDR(OWN_ADDR), .ADDR10(ADDR10)) u_slave (
        .clk       (clk),
        .rst       (rst),
        .enable    (!master_mode),
        .sl_start  (sl_start),
        .sl_stop   (sl_stop),
        .sl_vld    (sl_vld),
        .sl_byte   (sl_byte),
        .sl_ack    (sl_ack),
        .dump_addr (dump_addr),
        .prog_done (prog_done)
    );

    hwm_master_tx #(.OWN_ADDR(OWN_ADDR)) u_master (
        .clk      (clk),
        .rst      (rst),
        .enable   (master_mode),
        .bus_free (m_bus_free),
        .cmd_vld  (m_cmd_vld),
        .cmd      (m_cmd),
        .txd      (m_txd),
        .rsp_vld  (m_rsp_vld),
        .rsp_ack  (m_rsp_ack),
        .arb_lost (m_arb_lost),
        .src_vld  (src_vld),
        .src_data (src_data),
        .src_last (src_last),
        .src_pop  (src_pop),
        .err      (err)
    );

    p_silent_master_r12: assert property (@(posedge clk) disable iff (rst)
        master_mode |-> !sl_ack);

    p_role_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        master_mode |=> master_mode);

    p_no_cmd_as_slave_r1: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> !m_cmd_vld);
endmodule

// File: tb/tb_selfinit_hw_master.sv
`timescale 1ns/1ps
module tb_selfinit_hw_master;
    localparam real CLK_NS = 8.0;
    localparam logic [9:0] OWN7  = 10'h02C;
    localparam logic [9:0] OWN10 = 10'h2B5;
    localparam logic [7:0] ADR7_W  = {OWN7[6:0], 1'b0};
    localparam logic [7:0] ADR10_W = {5'b11110, OWN10[9:8], 1'b0};
    localparam logic [7:0] ID7     = {OWN7[6:0], 1'b1};
    localparam logic [1:0] C_START = 2'b01, C_BYTE = 2'b10, C_STOP = 2'b11;

    logic clk = 1'b0, rst = 1'b1;
    logic sl_start = 0, sl_stop = 0, sl_vld = 0;
    logic [7:0] sl_byte = 0;
    logic sl_ack, sl_ack10;
    logic m_bus_free = 1, m_rsp_vld = 0, m_rsp_ack = 0, m_arb_lost = 0;
    logic m_cmd_vld, src_pop, master_mode, err;
    logic [1:0] m_cmd;
    logic [7:0] m_txd, dump_addr;
    logic [7:0] src_mem [0:7];
    int src_idx = 0, src_n = 0;
    logic src_vld, src_last;
    logic [7:0] src_data;
    logic m_cmd_vld10, src_pop10, master10, err10;
    logic [1:0] m_cmd10;
    logic [7:0] m_txd10, dump10;
    int tests = 0, fails = 0;

    assign src_vld  = (src_idx < src_n);
    assign src_data = src_mem[src_idx[2:0]];
    assign src_last = (src_idx == src_n - 1);

    always #(CLK_NS/2) clk = ~clk;

    selfinit_hw_master #(.OWN_ADDR(OWN7), .ADDR10(1'b0)) dut (
        .clk(clk), .rst(rst), .sl_start(sl_start), .sl_stop(sl_stop),
        .sl_vld(sl_vld), .sl_byte(sl_byte), .sl_ack(sl_ack),
        .m_bus_free(m_bus_free), .m_cmd_vld(m_cmd_vld), .m_cmd(m_cmd),
        .m_txd(m_txd), .m_rsp_vld(m_rsp_vld), .m_rsp_ack(m_rsp_ack),
        .m_arb_lost(m_arb_lost), .src_vld(src_vld), .src_data(src_data),
        .src_last(src_last), .src_pop(src_pop), .master_mode(master_mode),
        .dump_addr(dump_addr), .err(err));

    selfinit_hw_master #(.OWN_ADDR(OWN10), .ADDR10(1'b1)) dut10 (
        .clk(clk), .rst(rst), .sl_start(sl_start), .sl_stop(sl_stop),
        .sl_vld(sl_vld), .sl_byte(sl_byte), .sl_ack(sl_ack10),
        .m_bus_free(1'b0), .m_cmd_vld(m_cmd_vld10), .m_cmd(m_cmd10),
        .m_txd(m_txd10), .m_rsp_vld(1'b0), .m_rsp_ack(1'b0),
        .m_arb_lost(1'b0), .src_vld(1'b0), .src_data(8'h00),
        .src_last(1'b0), .src_pop(src_pop10), .master_mode(master10),
        .dump_addr(dump10), .err(err10));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // all stimulus tasks begin and end on a falling edge
    task automatic bus_start;
        sl_start = 1; @(negedge clk); sl_start = 0;
    endtask
    task automatic bus_stop;
        sl_stop = 1; @(negedge clk); sl_stop = 0;
    endtask
    task automatic bus_byte(input logic [7:0] b, output logic a7, output logic a10);
        sl_vld = 1; sl_byte = b; #2; a7 = sl_ack; a10 = sl_ack10;
        @(negedge clk); sl_vld = 0;
    endtask

    task automatic expect_cmd(input logic [1:0] code, input logic [7:0] data, input string req);
        int n = 0;
        #2;
        while (!m_cmd_vld && n < 20) begin @(negedge clk); #2; n++; end
        chk(req, m_cmd_vld, 1);
        chk(req, m_cmd, code);
        if (code == C_BYTE) chk(req, m_txd, data);
        @(negedge clk);
    endtask

    task automatic respond(input logic ack, input logic arb, input logic exp_pop, input string req);
        logic popped;
        m_rsp_vld = !arb; m_arb_lost = arb; m_rsp_ack = ack;
        #2; popped = src_pop;
        chk(req, popped, exp_pop);
        @(negedge clk);
        m_rsp_vld = 0; m_arb_lost = 0; m_rsp_ack = 0;
        if (popped) src_idx++;
    endtask

    task automatic idle_check(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            #2; chk(req, m_cmd_vld, 0); @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog R1..: act=timeout exp=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a7, a10;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sl_ack", sl_ack, 0);
        chk("R1 cmd_vld", m_cmd_vld, 0);
        chk("R1 master_mode", master_mode, 0);
        chk("R1 dump_addr", dump_addr, 0);
        chk("R1 err", err, 0);
        chk("R1 src_pop", src_pop, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 after release", {master_mode, m_cmd_vld, err}, 0);

        // R2 / R3 / R4 / R6: sweep every first byte in both modes
        for (int b = 0; b < 256; b++) begin
            bus_start();
            bus_byte(b[7:0], a7, a10);
            chk(b[0] ? "R4 7-bit first byte" : "R2 7-bit first byte",
                a7, (b[7:0] == ADR7_W));
            chk(b[0] ? "R4 10-bit first byte" : "R3 10-bit first byte",
                a10, (b[7:0] == ADR10_W));
            bus_stop();
        end
        chk("R6 still slave (7-bit)", master_mode, 0);
        chk("R6 still slave (10-bit)", master10, 0);

        // R5: program destination on the 7-bit device
        bus_start();
        bus_byte(ADR7_W, a7, a10);
        chk("R5 address ack", a7, 1);
        bus_byte(8'h5A, a7, a10);
        chk("R5 destination ack", a7, 1);
        bus_byte(8'h77, a7, a10);
        chk("R5 extra byte refused", a7, 0);
        chk("R5 before stop", master_mode, 0);
        bus_stop();
        chk("R5 master after stop", master_mode, 1);
        chk("R5 destination", dump_addr, 8'h5A);

        // R12: former address, general call and reads are all ignored
        bus_start();
        bus_byte(ADR7_W, a7, a10); chk("R12 former address", a7, 0);
        bus_byte(8'h00, a7, a10);  chk("R12 general call", a7, 0);
        bus_byte(ID7, a7, a10);    chk("R12 read", a7, 0);
        bus_stop();
        chk("R12 role kept", master_mode, 1);
        chk("R12 destination kept", dump_addr, 8'h5A);
        idle_check(3, "R7 no command without data");

        // R7 / R8: normal transfer of three bytes
        src_mem[0] = 8'h11; src_mem[1] = 8'h22; src_mem[2] = 8'h33;
        src_idx = 0; src_n = 3;
        expect_cmd(C_START, 0, "R7 start");   respond(1, 0, 0, "R7 no pop");
        expect_cmd(C_BYTE, 8'h00, "R7 gc");   respond(1, 0, 0, "R7 no pop");
        expect_cmd(C_BYTE, ID7, "R7 id");     respond(1, 0, 0, "R7 no pop");
        expect_cmd(C_BYTE, 8'h11, "R8 d0");   respond(1, 0, 1, "R8 pop d0");
        expect_cmd(C_BYTE, 8'h22, "R8 d1");   respond(1, 0, 1, "R8 pop d1");
        expect_cmd(C_BYTE, 8'h33, "R8 d2");   respond(1, 0, 1, "R8 pop d2");
        expect_cmd(C_STOP, 0, "R8 stop");     respond(1, 0, 0, "R8 stop no pop");
        idle_check(2, "R8 idle after stop");
        chk("R8 all popped", src_idx, 3);

        // R9: refused data byte
        src_mem[0] = 8'h44; src_mem[1] = 8'h55; src_mem[2] = 8'h66;
        src_idx = 0; src_n = 3;
        expect_cmd(C_START, 0, "R9 start");   respond(1, 0, 0, "R9 no pop");
        expect_cmd(C_BYTE, 8'h00, "R9 gc");   respond(1, 0, 0, "R9 no pop");
        expect_cmd(C_BYTE, ID7, "R9 id");     respond(1, 0, 0, "R9 no pop");
        expect_cmd(C_BYTE, 8'h44, "R9 d0");   respond(1, 0, 1, "R9 pop d0");
        expect_cmd(C_BYTE, 8'h55, "R9 d1");   respond(0, 0, 1, "R9 pop d1");
        m_bus_free = 0;
        expect_cmd(C_STOP, 0, "R9 stop");     respond(1, 0, 0, "R9 stop");
        idle_check(4, "R10 waits for free bus");
        chk("R9 remaining kept", src_idx, 2);

        // R10: arbitration lost during the header, then retried in full
        m_bus_free = 1;
        expect_cmd(C_START, 0, "R10 start");  respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, 8'h00, "R10 gc");  respond(1, 1, 0, "R10 lost no pop");
        #2; chk("R10 released", m_cmd_vld, 0); @(negedge clk);
        expect_cmd(C_START, 0, "R10 restart"); respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, 8'h00, "R10 gc again"); respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, ID7, "R10 id");    respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, 8'h66, "R10 data"); respond(1, 1, 0, "R10 lost data no pop");
        #2; chk("R10 released in data", m_cmd_vld, 0); @(negedge clk);
        expect_cmd(C_START, 0, "R10 restart 2"); respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, 8'h00, "R10 gc 2"); respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, ID7, "R10 id 2");  respond(1, 0, 0, "R10 no pop");
        expect_cmd(C_BYTE, 8'h66, "R10 data 2"); respond(1, 0, 1, "R10 pop");
        m_bus_free = 0;
        expect_cmd(C_STOP, 0, "R10 stop");    respond(1, 0, 0, "R10 stop");
        chk("R11 err clear so far", err, 0);

        // R11: refused general call
        src_mem[0] = 8'h77; src_idx = 0; src_n = 1;
        m_bus_free = 1;
        expect_cmd(C_START, 0, "R11 start");  respond(1, 0, 0, "R11 no pop");
        expect_cmd(C_BYTE, 8'h00, "R11 gc");  respond(0, 0, 0, "R11 no pop");
        m_bus_free = 0;
        expect_cmd(C_STOP, 0, "R11 stop not data"); respond(1, 0, 0, "R11 stop");
        chk("R11 err set", err, 1);
        idle_check(3, "R11 no data sent");
        chk("R11 err sticky", err, 1);
        chk("R11 nothing popped", src_idx, 0);

        // R3 / R5 on the 10-bit device; R12 on the 7-bit one
        bus_start();
        bus_byte(ADR10_W, a7, a10); chk("R3 high part", a10, 1);
        chk("R12 7-bit silent", a7, 0);
        bus_byte(8'h11, a7, a10);   chk("R3 wrong low byte", a10, 0);
        bus_stop();
        bus_start();
        bus_byte(ADR10_W, a7, a10); chk("R3 high part again", a10, 1);
        bus_byte(OWN10[7:0], a7, a10); chk("R3 low byte", a10, 1);
        bus_byte(8'h3C, a7, a10);   chk("R5 10-bit destination ack", a10, 1);
        chk("R5 10-bit before stop", master10, 0);
        bus_stop();
        chk("R5 10-bit master", master10, 1);
        chk("R5 10-bit destination", dump10, 8'h3C);
        bus_start();
        bus_byte(ADR10_W, a7, a10); chk("R12 10-bit silent", a10, 0);
        bus_stop();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule